// File: doc/BRIEF.md
# Shared Script Memory Access Controller

This block sits in front of an on-chip word memory that holds programs and table data for an embedded script processor. Two requesters compete for it. The processor's master port issues instruction fetches, table reads, loads, stores and move transfers. When the address falls inside a relocatable 8 KB window and the bypass is not disabled, the access is served locally and never reaches the host bus. Otherwise the request is passed on through a forward strobe to the external bus engine. The host-bus slave port reaches the same memory with byte enables. When it collides with a local cycle, it receives a retry instead of being stalled.

A small register file holds the 64-bit window base, split into low and high words, and a control word with a bypass-disable bit and a mirror-enable bit. When the mirror bit is set, the low base word is also readable through a mirror register. A status register has a sticky error bit. It is raised when any read touches a word whose four bytes have not all been written. It is cleared by writing one to it.

A three-state controller arbitrates the memory. `ST_IDLE` accepts either requester, and the processor wins a tie. `ST_INT` is the cycle after a processor access was accepted. `ST_EXT` is the cycle after a host access was accepted. The transitions are:
- `IDLE_TO_INT`: a processor hit is accepted.
- `IDLE_TO_EXT`: a host hit is accepted with no processor hit.
- `INT_TO_INT`: a back-to-back processor hit is accepted.
- `INT_TO_IDLE`: there is no processor hit.
- `EXT_TO_IDLE`: always, with nothing accepted in `ST_EXT`.
- `IDLE_HOLD`: no request is accepted.

Top module: `script_ram_ctrl`

## Requirements
- R1: The memory holds WORDS (default 2048) words of 32 bits. Read data appears on `im_rdata`/`hs_rdata`, with `im_rvalid`/`hs_rvalid` high, in the cycle after the read was accepted.
- R2: Register select 0 holds base bits [31:0] and select 1 holds bits [63:32]. Base bits [12:0] always read as zero. An address hits when base <= addr < base + 8192. The word index is (addr - base) bits [12:2].
- R3: With control bit 0 clear, a processor request that hits is accepted with `im_ack` high and `im_fwd` low. A processor request that misses drives `im_fwd` high and `im_ack` low.
- R4: With control bit 0 (select 2) set, every processor request drives `im_fwd` high and is never acknowledged.
- R5: A host hit is answered with `hs_retry` and no `hs_ack` in two cases: when it arrives in the same cycle as an accepted processor hit, and when it arrives in the `ST_INT` cycle.
- R6: After `hs_ack`, the next cycle accepts no request. A processor hit waiting there is acknowledged one cycle later.
- R7: Host and processor writes update only the bytes whose bit in the 4-bit byte enable is set. Bit b covers data bits [8b+7:8b].
- R8: A read of a word with any byte never written sets status (select 3) bit 7. The bit stays set through later clean reads.
- R9: Writing select 3 with data bit 7 set clears status bit 7. Writing it with bit 7 clear leaves the bit unchanged.
- R10: Select 4 returns base bits [31:0] when control bit 3 is set, and zero otherwise.
- R11: A host request outside the window gets neither `hs_ack` nor `hs_retry`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| im_req | input | 1 | Processor request, held until acknowledged |
| im_we | input | 1 | Processor write |
| im_addr | input | 64 | Processor byte address |
| im_be | input | 4 | Processor byte enables |
| im_wdata | input | 32 | Processor write data |
| im_ack | output | 1 | Processor access accepted locally |
| im_fwd | output | 1 | Processor access must go to the host bus |
| im_rvalid | output | 1 | Processor read data valid |
| im_rdata | output | 32 | Processor read data |
| hs_req | input | 1 | Host slave request |
| hs_we | input | 1 | Host write |
| hs_addr | input | 64 | Host byte address |
| hs_be | input | 4 | Host byte enables |
| hs_wdata | input | 32 | Host write data |
| hs_ack | output | 1 | Host access accepted |
| hs_retry | output | 1 | Host access must be retried |
| hs_rvalid | output | 1 | Host read data valid |
| hs_rdata | output | 32 | Host read data |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select (0..4) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data |

## Verification
The hardest situation to reach is a host retry that lands in the `ST_INT` cycle rather than in the accept cycle. To get there, the processor and the host are driven into the same cycle and the host request is held high afterwards. The retry is then seen twice before the host is finally accepted from `ST_IDLE`. The mirror case is produced in a similar way. A host read is accepted, and a processor hit is raised in the `ST_EXT` cycle, where it must wait exactly one cycle. A sweep over all fifteen non-zero byte-enable patterns leaves words partly written. Each partial read must raise the sticky error and must return exactly the merged bytes the bench computes.

// File: rtl/smem_pkg.sv
package smem_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_INT  = 2'd1,
        ST_EXT  = 2'd2
    } smem_state_t;

    localparam logic [2:0] SEL_BASE_LO = 3'd0;
    localparam logic [2:0] SEL_BASE_HI = 3'd1;
    localparam logic [2:0] SEL_CTRL    = 3'd2;
    localparam logic [2:0] SEL_STATUS  = 3'd3;
    localparam logic [2:0] SEL_MIRROR  = 3'd4;

    localparam int CTRL_DIS_BIT    = 0;
    localparam int CTRL_MIRROR_BIT = 3;
    localparam int STAT_PERR_BIT   = 7;
endpackage

// File: rtl/smem_window.sv
module smem_window #(
    parameter int ADDR_W    = 64,
    parameter int WIN_BYTES = 8192,
    parameter int OFF_W     = 13
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [ADDR_W-1:0] base,
    output logic              hit,
    output logic [OFF_W-1:0]  off
);
    logic [ADDR_W-1:0] diff;

    always_comb begin
        diff = addr - base;
        hit  = (addr >= base) && (diff < ADDR_W'(WIN_BYTES));
        off  = diff[OFF_W-1:0];
    end
endmodule

// File: rtl/smem_store.sv
module smem_store #(
    parameter int WORDS = 2048,
    parameter int BYTES = 4,
    localparam int IDX_W = $clog2(WORDS),
    localparam int DW    = BYTES * 8
) (
    input  logic             clk,
    input  logic             we,
    input  logic             re,
    input  logic [BYTES-1:0] be,
    input  logic [IDX_W-1:0] idx,
    input  logic [DW-1:0]    wdata,
    output logic [DW-1:0]    rdata
);
    logic [DW-1:0] mem [WORDS];

    for (genvar b = 0; b < BYTES; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (we && be[b]) begin
                mem[idx][8*b +: 8] <= wdata[8*b +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (re) begin
            rdata <= mem[idx];
        end
    end
endmodule

// File: rtl/smem_init_track.sv
module smem_init_track #(
    parameter int WORDS = 2048,
    parameter int BYTES = 4,
    localparam int IDX_W = $clog2(WORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [BYTES-1:0] be,
    input  logic [IDX_W-1:0] idx,
    output logic             uninit
);
    logic [BYTES-1:0] seen [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < WORDS; i++) begin
                seen[i] <= '0;
            end
        end else if (we) begin
            seen[idx] <= seen[idx] | be;
        end
    end

    assign uninit = (seen[idx] != {BYTES{1'b1}});
endmodule

// File: rtl/script_ram_ctrl.sv
module script_ram_ctrl
    import smem_pkg::*;
#(
    parameter int WORDS  = 2048,
    parameter int ADDR_W = 64,
    localparam int BYTES     = 4,
    localparam int DW        = BYTES * 8,
    localparam int IDX_W     = $clog2(WORDS),
    localparam int OFF_W     = IDX_W + 2,
    localparam int WIN_BYTES = WORDS * BYTES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              im_req,
    input  logic              im_we,
    input  logic [ADDR_W-1:0] im_addr,
    input  logic [BYTES-1:0]  im_be,
    input  logic [DW-1:0]     im_wdata,
    output logic              im_ack,
    output logic              im_fwd,
    output logic              im_rvalid,
    output logic [DW-1:0]     im_rdata,
    input  logic              hs_req,
    input  logic              hs_we,
    input  logic [ADDR_W-1:0] hs_addr,
    input  logic [BYTES-1:0]  hs_be,
    input  logic [DW-1:0]     hs_wdata,
    output logic              hs_ack,
    output logic              hs_retry,
    output logic              hs_rvalid,
    output logic [DW-1:0]     hs_rdata,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);
    smem_state_t state_q, state_d;

    logic [ADDR_W-1:0] base_q;
    logic [31:0]       ctrl_q;
    logic              perr_q;
    logic              im_rv_q, hs_rv_q;

    logic             im_hit, hs_hit;
    logic [OFF_W-1:0] im_off, hs_off;
    logic             im_local, im_go, hs_go;

    logic             m_we, m_re;
    logic [BYTES-1:0] m_be;
    logic [IDX_W-1:0] m_idx;
    logic [DW-1:0]    m_wdata, m_rdata;
    logic             m_uninit;
    logic             perr_clr, perr_set;

    smem_window #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .OFF_W(OFF_W)) u_im_win (
        .addr(im_addr), .base(base_q), .hit(im_hit), .off(im_off)
    );

    smem_window #(.ADDR_W(ADDR_W), .WIN_BYTES(WIN_BYTES), .OFF_W(OFF_W)) u_hs_win (
        .addr(hs_addr), .base(base_q), .hit(hs_hit), .off(hs_off)
    );

    assign im_local = im_req && im_hit && !ctrl_q[CTRL_DIS_BIT];
    assign im_fwd   = im_req && !(im_hit && !ctrl_q[CTRL_DIS_BIT]);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Next state and handshake outputs
    always_comb begin
        state_d  = ST_IDLE;
        im_go    = 1'b0;
        hs_go    = 1'b0;
        hs_retry = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (im_local) begin
                    im_go    = 1'b1;
                    hs_retry = hs_req && hs_hit;
                    state_d  = ST_INT;
                end else if (hs_req && hs_hit) begin
                    hs_go   = 1'b1;
                    state_d = ST_EXT;
                end
            end
            ST_INT: begin
                hs_retry = hs_req && hs_hit;
                if (im_local) begin
                    im_go   = 1'b1;
                    state_d = ST_INT;
                end
            end
            ST_EXT: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    assign im_ack = im_go;
    assign hs_ack = hs_go;

    // Memory port multiplexer
    always_comb begin
        m_idx   = im_go ? im_off[OFF_W-1:2] : hs_off[OFF_W-1:2];
        m_be    = im_go ? im_be : hs_be;
        m_wdata = im_go ? im_wdata : hs_wdata;
        m_we    = (im_go && im_we) || (hs_go && hs_we);
        m_re    = (im_go && !im_we) || (hs_go && !hs_we);
    end

    smem_store #(.WORDS(WORDS), .BYTES(BYTES)) u_store (
        .clk(clk), .we(m_we), .re(m_re), .be(m_be), .idx(m_idx),
        .wdata(m_wdata), .rdata(m_rdata)
    );

    smem_init_track #(.WORDS(WORDS), .BYTES(BYTES)) u_track (
        .clk(clk), .rst_n(rst_n), .we(m_we), .be(m_be), .idx(m_idx),
        .uninit(m_uninit)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            im_rv_q <= 1'b0;
            hs_rv_q <= 1'b0;
        end else begin
            im_rv_q <= im_go && !im_we;
            hs_rv_q <= hs_go && !hs_we;
        end
    end

    assign im_rvalid = im_rv_q;
    assign hs_rvalid = hs_rv_q;
    assign im_rdata  = m_rdata;
    assign hs_rdata  = m_rdata;

    // Register file
    assign perr_set = m_re && m_uninit;
    assign perr_clr = reg_we && (reg_sel == SEL_STATUS) && reg_wdata[STAT_PERR_BIT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            ctrl_q <= '0;
            perr_q <= 1'b0;
        end else begin
            if (reg_we && reg_sel == SEL_BASE_LO) begin
                base_q[31:0] <= {reg_wdata[31:13], 13'd0};
            end
            if (reg_we && reg_sel == SEL_BASE_HI) begin
                base_q[ADDR_W-1:32] <= reg_wdata[ADDR_W-33:0];
            end
            if (reg_we && reg_sel == SEL_CTRL) begin
                ctrl_q <= reg_wdata;
            end
            if (perr_set) begin
                perr_q <= 1'b1;
            end else if (perr_clr) begin
                perr_q <= 1'b0;
            end
        end
    end

    always_comb begin
        reg_rdata = '0;
        unique case (reg_sel)
            SEL_BASE_LO: reg_rdata = base_q[31:0];
            SEL_BASE_HI: reg_rdata = base_q[ADDR_W-1:32];
            SEL_CTRL:    reg_rdata = ctrl_q;
            SEL_STATUS:  reg_rdata[STAT_PERR_BIT] = perr_q;
            SEL_MIRROR:  reg_rdata = ctrl_q[CTRL_MIRROR_BIT] ? base_q[31:0] : 32'd0;
            default:     reg_rdata = '0;
        endcase
    end

    // Checks
    AST_ACCEPT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (im_ack && !im_we) |=> im_rvalid); // R1
    AST_FWD_NOT_LOCAL: assert property (@(posedge clk) disable iff (!rst_n)
        im_fwd |-> !im_ack); // R3
    AST_RETRY_NOT_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_ack && hs_retry)); // R5
    AST_COLLIDE_INT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        im_ack |-> !hs_ack); // R5
    AST_EXT_FINISHES: assert property (@(posedge clk) disable iff (!rst_n)
        hs_ack |=> (!hs_ack && !im_ack)); // R6
    AST_PERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (perr_q && !perr_clr) |=> perr_q); // R8
    AST_BASE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        base_q[12:0] == 13'd0); // R2
endmodule

// File: tb/sim_script_ram_ctrl.sv
`timescale 1ns/1ps
module sim_script_ram_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        im_req = 0, im_we = 0;
    logic [63:0] im_addr = '0;
    logic [3:0]  im_be = '0;
    logic [31:0] im_wdata = '0;
    logic        im_ack, im_fwd, im_rvalid;
    logic [31:0] im_rdata;
    logic        hs_req = 0, hs_we = 0;
    logic [63:0] hs_addr = '0;
    logic [3:0]  hs_be = '0;
    logic [31:0] hs_wdata = '0;
    logic        hs_ack, hs_retry, hs_rvalid;
    logic [31:0] hs_rdata;
    logic        reg_we = 0;
    logic [2:0]  reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;

    int checks = 0;
    int fails = 0;
    bit done = 0;

    localparam logic [63:0] BASE = 64'h0000_0001_8000_2000;

    script_ram_ctrl u0 (.*);

    always #2 clk = ~clk;

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic reg_wr(input logic [2:0] sel, input logic [31:0] d);
        reg_we = 1; reg_sel = sel; reg_wdata = d;
        tick;
        reg_we = 0;
    endtask

    task automatic reg_rd(input logic [2:0] sel, output logic [31:0] d);
        reg_sel = sel;
        #0.5;
        d = reg_rdata;
    endtask

    task automatic hs_op(input logic we, input logic [63:0] a, input logic [3:0] be,
                         input logic [31:0] wd, output logic ack, output logic rty,
                         output logic [31:0] rd, output logic rv);
        hs_req = 1; hs_we = we; hs_addr = a; hs_be = be; hs_wdata = wd;
        #1;
        ack = hs_ack; rty = hs_retry;
        tick;
        hs_req = 0;
        rd = hs_rdata; rv = hs_rvalid;
    endtask

    task automatic im_op(input logic we, input logic [63:0] a, input logic [3:0] be,
                         input logic [31:0] wd, output logic ack, output logic fwd,
                         output logic [31:0] rd, output logic rv);
        im_req = 1; im_we = we; im_addr = a; im_be = be; im_wdata = wd;
        #1;
        ack = im_ack; fwd = im_fwd;
        tick;
        im_req = 0;
        rd = im_rdata; rv = im_rvalid;
    endtask

    function automatic logic [31:0] bmask(input logic [3:0] be);
        logic [31:0] m;
        for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
        return m;
    endfunction

    initial begin
        #200000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog actual=%h expected=%h", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        logic ack, rty, fwd, rv;
        logic [31:0] rd, r;
        logic [31:0] model [16];

        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        tick;

        // Reset state
        reg_rd(3'd0, r); chk(r == 0, "R2 reset base", r, 0);
        reg_rd(3'd3, r); chk(r == 0, "R8 reset status", r, 0);
        chk(!hs_ack && !im_ack && !hs_retry, "R1 reset idle", {hs_ack, im_ack, hs_retry}, 0);

        // Base programming and alignment
        reg_wr(3'd0, BASE[31:0] | 32'h1ABC);
        reg_wr(3'd1, BASE[63:32]);
        reg_rd(3'd0, r); chk(r == BASE[31:0], "R2 base low aligned", r, BASE[31:0]);
        reg_rd(3'd1, r); chk(r == BASE[63:32], "R2 base high", r, BASE[63:32]);

        // Mirror register
        reg_rd(3'd4, r); chk(r == 0, "R10 mirror off", r, 0);
        reg_wr(3'd2, 32'h8);
        reg_rd(3'd4, r); chk(r == BASE[31:0], "R10 mirror on", r, BASE[31:0]);
        reg_wr(3'd2, 32'h0);

        // Byte-enable sweep over all patterns
        for (int w = 0; w < 16; w++) begin
            logic [3:0] be;
            logic [31:0] wd;
            be = (w == 0) ? 4'hF : w[3:0];
            wd = 32'hC3A5_5A3C ^ (w * 32'h0101_0101);
            hs_op(1, BASE + 64'(w * 4), be, wd, ack, rty, rd, rv);
            chk(ack && !rty, "R7 host write ack", {ack, rty}, 2'b10);
            model[w] = wd & bmask(be);
            reg_wr(3'd3, 32'h80);
            hs_op(0, BASE + 64'(w * 4), 4'h0, 0, ack, rty, rd, rv);
            chk(rv && ((rd & bmask(be)) == model[w]), "R7 partial merge", rd & bmask(be), model[w]);
            tick;
            reg_rd(3'd3, r);
            chk(r[7] == (be != 4'hF), "R8 uninit flag", r[7], be != 4'hF);
            // Complete remaining bytes
            if (be != 4'hF) begin
                hs_op(1, BASE + 64'(w * 4), ~be, ~wd, ack, rty, rd, rv);
                model[w] = model[w] | (~wd & bmask(~be));
            end
            reg_wr(3'd3, 32'h80);
            im_op(0, BASE + 64'(w * 4), 4'h0, 0, ack, fwd, rd, rv);
            chk(ack && !fwd && rv && rd == model[w], "R3 local full read", rd, model[w]);
            tick;
            reg_rd(3'd3, r); chk(r[7] == 0, "R8 clean read no flag", r[7], 0);
        end

        // Sticky and write-one-to-clear
        hs_op(0, BASE + 64'h100, 4'h0, 0, ack, rty, rd, rv);
        tick;
        hs_op(0, BASE, 4'h0, 0, ack, rty, rd, rv);
        tick;
        reg_rd(3'd3, r); chk(r[7] == 1, "R8 sticky after clean read", r[7], 1);
        reg_wr(3'd3, 32'h7F);
        reg_rd(3'd3, r); chk(r[7] == 1, "R9 write zero keeps", r[7], 1);
        reg_wr(3'd3, 32'h80);
        reg_rd(3'd3, r); chk(r[7] == 0, "R9 write one clears", r[7], 0);

        // Window boundaries
        im_op(1, BASE + 64'd8188, 4'hF, 32'hDEAD_BEEF, ack, fwd, rd, rv);
        chk(ack && !fwd, "R2 last word hits", {ack, fwd}, 2'b10);
        tick;
        hs_op(0, BASE + 64'd8188, 4'h0, 0, ack, rty, rd, rv);
        chk(rv && rd == 32'hDEAD_BEEF, "R1 last word readback", rd, 32'hDEAD_BEEF);
        tick;
        im_op(0, BASE + 64'd8192, 4'h0, 0, ack, fwd, rd, rv);
        chk(!ack && fwd, "R3 above window forwards", {ack, fwd}, 2'b01);
        im_op(0, BASE - 64'd4, 4'h0, 0, ack, fwd, rd, rv);
        chk(!ack && fwd, "R3 below window forwards", {ack, fwd}, 2'b01);
        hs_op(0, BASE + 64'd8192, 4'h0, 0, ack, rty, rd, rv);
        chk(!ack && !rty, "R11 host outside ignored", {ack, rty}, 0);
        hs_op(0, BASE - 64'd4, 4'h0, 0, ack, rty, rd, rv);
        chk(!ack && !rty, "R11 host below ignored", {ack, rty}, 0);

        // Disable bypass
        reg_wr(3'd2, 32'h1);
        im_op(0, BASE, 4'h0, 0, ack, fwd, rd, rv);
        chk(!ack && fwd, "R4 disabled forwards", {ack, fwd}, 2'b01);
        reg_wr(3'd2, 32'h0);
        im_op(0, BASE, 4'h0, 0, ack, fwd, rd, rv);
        chk(ack && !fwd, "R4 re-enabled local", {ack, fwd}, 2'b10);
        tick;

        // Collision: same cycle, then during ST_INT
        im_req = 1; im_we = 0; im_addr = BASE + 4;
        hs_req = 1; hs_we = 0; hs_addr = BASE + 8;
        #1;
        chk(im_ack && hs_retry && !hs_ack, "R5 same cycle retry", {im_ack, hs_retry, hs_ack}, 3'b110);
        tick;
        im_req = 0;
        #1;
        chk(hs_retry && !hs_ack, "R5 retry during internal cycle", {hs_retry, hs_ack}, 2'b10);
        chk(im_rvalid && im_rdata == model[1], "R1 internal data", im_rdata, model[1]);
        tick;
        #1;
        chk(hs_ack && !hs_retry, "R5 host accepted after", {hs_ack, hs_retry}, 2'b10);
        tick;
        hs_req = 0;
        chk(hs_rvalid && hs_rdata == model[2], "R1 host data", hs_rdata, model[2]);

        // Host in progress, internal waits one cycle
        tick;
        hs_req = 1; hs_we = 0; hs_addr = BASE + 12;
        #1;
        chk(hs_ack, "R6 host accepted", hs_ack, 1);
        tick;
        hs_req = 0;
        im_req = 1; im_we = 0; im_addr = BASE + 16;
        #1;
        chk(!im_ack, "R6 internal waits in ext cycle", im_ack, 0);
        chk(hs_rdata == model[3], "R1 host data ext", hs_rdata, model[3]);
        tick;
        #1;
        chk(im_ack, "R6 internal accepted next", im_ack, 1);
        tick;
        im_req = 0;
        chk(im_rvalid && im_rdata == model[4], "R1 internal after ext", im_rdata, model[4]);

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule